// File: doc/BRIEF.md
# Affine multiple matrix builder for a cubic over GF(2^m)

This block prepares the root-finding step of a three-error binary BCH decoder. It receives the four scaled coefficients A, B, C and D of a cubic error locator over GF(2^m), with A nonzero. It multiplies the cubic by (A z + B). In characteristic 2 the cubic term of the product cancels, which leaves an affine polynomial: a linearized part plus a constant. The roots of the cubic are among the roots of that affine polynomial.

The linearized part L(z) is GF(2)-linear in the bits of z. Evaluating it at each polynomial-basis element therefore gives an m×m binary matrix. A field element Z is a root of the affine polynomial exactly when the XOR of the matrix rows picked by the set bits of Z equals the constant term. The block produces this matrix one row per clock and presents the constant as a vector. It signals completion with a single done pulse. A downstream solver consumes the system.

Top module: `afm_matrix_builder`

## Requirements
- R1: After reset, busy, done and err are low, and mat_rows and vec_u are all zero.
- R2: For an accepted start with coef_a nonzero, the affine coefficients are A², A·C+B², B·C+A·D and B·D. These are the quartic, quadratic, linear and constant terms. vec_u shows B·D from the cycle after the start edge and holds it until the next accepted start. Field bit j is the coefficient of α^j, reduced by the primitive polynomial whose low m bits are POLY.
- R3: Row i of the matrix occupies mat_rows[i*M+M-1 : i*M]. It holds L(α^i) = A²·α^(4i) + (A·C+B²)·α^(2i) + (B·C+A·D)·α^i, where α^i is the element with only bit i set.
- R4: A start sampled at edge k with coef_a nonzero sets busy from edge k+1 and writes row i at edge k+1+i. After edge k+M, done is high for exactly one cycle and busy is low.
- R5: A start sampled while idle with coef_a zero sets err after that edge, with no busy and no done. It clears mat_rows and vec_u. err stays high until the next accepted start, which clears it.
- R6: A start while busy is ignored. The running build completes with the coefficients it began with.
- R7: For the GF(16) case with α⁴+α+1 and the cubic z³+α¹³z²+z+α³, the finished system is solved by Z = α¹² (4'b1111) and by Z = α¹³ (4'b1101). For each of these, the XOR of the selected rows equals vec_u.
- R8: An accepted start clears all of mat_rows, so rows not yet written read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a build; sampled only when idle |
| coef_a | input | M | Cubic coefficient A (z³ term) |
| coef_b | input | M | Cubic coefficient B (z² term) |
| coef_c | input | M | Cubic coefficient C (z term) |
| coef_d | input | M | Cubic coefficient D (constant) |
| busy | output | 1 | A build is in progress |
| done | output | 1 | One-cycle pulse when all rows are valid |
| err | output | 1 | Last accepted start had coef_a equal to zero |
| mat_rows | output | M*M | Matrix, row i at bits [i*M +: M] |
| vec_u | output | M | Constant term B·D of the affine multiple |

## Verification
A wrong affine coefficient register shows up in one of two ways. If the constant is wrong, vec_u is wrong in the very first cycle after start. If another coefficient is wrong, every row differs from the reference as soon as that row is written, one cycle per row. A wrong row index or counter shows up as a row written in the wrong slot or a done pulse in the wrong cycle, which the per-clock model comparison flags within M cycles. A stuck state or error flag shows up as busy, done or err disagreeing with the model on the cycle after the offending start. The GF(16) example then ties the matrix to actual roots of the cubic.

// File: rtl/afm_pkg.sv
package afm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } afm_state_e;
endpackage

// File: rtl/afm_gf_mul.sv
module afm_gf_mul #(
    parameter int          M    = 4,
    parameter logic [M-1:0] POLY = 4'b0011
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] y
);
    logic [M-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0);
            if (b[i]) acc = acc ^ a;
        end
        y = acc;
    end
endmodule

// File: rtl/afm_gf_sqr.sv
module afm_gf_sqr #(
    parameter int          M    = 4,
    parameter logic [M-1:0] POLY = 4'b0011
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    localparam int W2 = 2 * M - 1;

    logic [W2-1:0] wide;

    always_comb begin
        wide = '0;
        for (int i = 0; i < M; i++) wide[2*i] = a[i];
        for (int k = W2 - 1; k >= M; k--) begin
            if (wide[k]) wide[k-M +: M] = wide[k-M +: M] ^ POLY;
        end
        y = wide[M-1:0];
    end
endmodule

// File: rtl/afm_coef_stage.sv
module afm_coef_stage #(
    parameter int          M    = 4,
    parameter logic [M-1:0] POLY = 4'b0011
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    input  logic [M-1:0] c,
    input  logic [M-1:0] d,
    output logic [M-1:0] k4,
    output logic [M-1:0] k2,
    output logic [M-1:0] k1,
    output logic [M-1:0] k0
);
    logic [M-1:0] a_sq, b_sq, ac, bc, ad, bd;

    afm_gf_sqr #(.M(M), .POLY(POLY)) i_sq_a (.a(a), .y(a_sq));
    afm_gf_sqr #(.M(M), .POLY(POLY)) i_sq_b (.a(b), .y(b_sq));
    afm_gf_mul #(.M(M), .POLY(POLY)) i_ac (.a(a), .b(c), .y(ac));
    afm_gf_mul #(.M(M), .POLY(POLY)) i_bc (.a(b), .b(c), .y(bc));
    afm_gf_mul #(.M(M), .POLY(POLY)) i_ad (.a(a), .b(d), .y(ad));
    afm_gf_mul #(.M(M), .POLY(POLY)) i_bd (.a(b), .b(d), .y(bd));

    assign k4 = a_sq;
    assign k2 = ac ^ b_sq;
    assign k1 = bc ^ ad;
    assign k0 = bd;
endmodule

// File: rtl/afm_basis_eval.sv
module afm_basis_eval #(
    parameter int          M    = 4,
    parameter logic [M-1:0] POLY = 4'b0011,
    parameter int          IW   = 2
) (
    input  logic [IW-1:0] idx,
    input  logic [M-1:0]  k4,
    input  logic [M-1:0]  k2,
    input  logic [M-1:0]  k1,
    output logic [M-1:0]  lval
);
    logic [M-1:0] z1, z2, z4, t4, t2, t1;

    always_comb begin
        z1 = '0;
        z1[idx] = 1'b1;
    end

    afm_gf_sqr #(.M(M), .POLY(POLY)) i_sq1 (.a(z1), .y(z2));
    afm_gf_sqr #(.M(M), .POLY(POLY)) i_sq2 (.a(z2), .y(z4));
    afm_gf_mul #(.M(M), .POLY(POLY)) i_m4 (.a(k4), .b(z4), .y(t4));
    afm_gf_mul #(.M(M), .POLY(POLY)) i_m2 (.a(k2), .b(z2), .y(t2));
    afm_gf_mul #(.M(M), .POLY(POLY)) i_m1 (.a(k1), .b(z1), .y(t1));

    assign lval = t4 ^ t2 ^ t1;
endmodule

// File: rtl/afm_matrix_builder.sv
module afm_matrix_builder #(
    parameter int          M    = 4,
    parameter logic [M-1:0] POLY = 4'b0011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [M-1:0]   coef_a,
    input  logic [M-1:0]   coef_b,
    input  logic [M-1:0]   coef_c,
    input  logic [M-1:0]   coef_d,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic [M*M-1:0] mat_rows,
    output logic [M-1:0]   vec_u
);
    import afm_pkg::*;

    localparam int            IW   = (M > 1) ? $clog2(M) : 1;
    localparam logic [IW-1:0] LAST = IW'(M - 1);

    typedef struct packed {
        afm_state_e     st;
        logic [IW-1:0]  idx;
        logic [M-1:0]   k4;
        logic [M-1:0]   k2;
        logic [M-1:0]   k1;
        logic [M-1:0]   k0;
        logic           done;
        logic           err;
        logic [M*M-1:0] rows;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [M-1:0] n4, n2, n1, n0, row_val;

    afm_coef_stage #(.M(M), .POLY(POLY)) i_coef (
        .a(coef_a), .b(coef_b), .c(coef_c), .d(coef_d),
        .k4(n4), .k2(n2), .k1(n1), .k0(n0)
    );

    afm_basis_eval #(.M(M), .POLY(POLY), .IW(IW)) i_eval (
        .idx(ctx_q.idx), .k4(ctx_q.k4), .k2(ctx_q.k2), .k1(ctx_q.k1),
        .lval(row_val)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.rows = '0;
                    ctx_d.idx  = '0;
                    if (coef_a == '0) begin
                        ctx_d.err = 1'b1;
                        ctx_d.k4  = '0;
                        ctx_d.k2  = '0;
                        ctx_d.k1  = '0;
                        ctx_d.k0  = '0;
                    end else begin
                        ctx_d.err = 1'b0;
                        ctx_d.k4  = n4;
                        ctx_d.k2  = n2;
                        ctx_d.k1  = n1;
                        ctx_d.k0  = n0;
                        ctx_d.st  = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                ctx_d.rows[int'(ctx_q.idx)*M +: M] = row_val;
                if (ctx_q.idx == LAST) begin
                    ctx_d.st   = ST_IDLE;
                    ctx_d.done = 1'b1;
                end else begin
                    ctx_d.idx = ctx_q.idx + 1'b1;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy     = (ctx_q.st == ST_EVAL);
    assign done     = ctx_q.done;
    assign err      = ctx_q.err;
    assign mat_rows = ctx_q.rows;
    assign vec_u    = ctx_q.k0;
endmodule

// File: rtl/afm_matrix_builder_chk.sv
module afm_matrix_builder_chk #(
    parameter int M = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [M-1:0] coef_a,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [M-1:0] vec_u
);
    // R4
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err && $past(busy)));

    // R4
    start_enters_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && coef_a != '0) |=> (busy && !err));

    // R5
    zero_lead_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && coef_a == '0) |=> (err && !busy && !done && vec_u == '0));

    // R2
    vec_held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(vec_u));

    // R6
    start_while_busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !err);
endmodule

bind afm_matrix_builder afm_matrix_builder_chk #(.M(M)) i_afm_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .coef_a(coef_a),
    .busy(busy), .done(done), .err(err), .vec_u(vec_u)
);

// File: tb/test_afm_matrix_builder.sv
module test_afm_matrix_builder;
    localparam int          M        = 4;
    localparam logic [M-1:0] POLY    = 4'b0011;
    localparam int          CLK_HALF = 5;
    localparam int          WD_LIMIT = 20000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [M-1:0]   coef_a = '0, coef_b = '0, coef_c = '0, coef_d = '0;
    logic           busy, done, err;
    logic [M*M-1:0] mat_rows;
    logic [M-1:0]   vec_u;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    afm_matrix_builder #(.M(M), .POLY(POLY)) i_afm_matrix_builder (
        .clk(clk), .rst_n(rst_n), .start(start),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c), .coef_d(coef_d),
        .busy(busy), .done(done), .err(err), .mat_rows(mat_rows), .vec_u(vec_u)
    );

    always #(CLK_HALF) clk = ~clk;

    // Behavioural field arithmetic
    function automatic logic [M-1:0] fmul(logic [M-1:0] x, logic [M-1:0] y);
        logic [M-1:0] r = '0;
        logic [M-1:0] s = x;
        for (int i = 0; i < M; i++) begin
            if (y[i]) r ^= s;
            s = s[M-1] ? ((s << 1) ^ POLY) : (s << 1);
        end
        return r;
    endfunction

    function automatic logic [M-1:0] lin_at(logic [M-1:0] a, logic [M-1:0] b,
                                            logic [M-1:0] c, logic [M-1:0] d,
                                            logic [M-1:0] z);
        logic [M-1:0] z2 = fmul(z, z);
        logic [M-1:0] z4 = fmul(z2, z2);
        return fmul(fmul(a, a), z4) ^ fmul(fmul(a, c) ^ fmul(b, b), z2)
               ^ fmul(fmul(b, c) ^ fmul(a, d), z);
    endfunction

    // Cycle-by-cycle reference
    int            m_left = 0;
    int            m_next = 0;
    logic [M-1:0]  m_a, m_b, m_c, m_d;
    logic [M-1:0]  m_rows [M];
    logic [M-1:0]  m_u = '0;
    bit            m_done = 0, m_err = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_left = 0; m_u = '0; m_done = 0; m_err = 0;
            foreach (m_rows[i]) m_rows[i] = '0;
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                m_rows[m_next] = lin_at(m_a, m_b, m_c, m_d, M'(1) << m_next);
                m_next++;
                m_left--;
                if (m_left == 0) m_done = 1;
            end else if (start) begin
                foreach (m_rows[i]) m_rows[i] = '0;
                if (coef_a == '0) begin
                    m_err = 1; m_u = '0;
                end else begin
                    m_err = 0;
                    m_a = coef_a; m_b = coef_b; m_c = coef_c; m_d = coef_d;
                    m_u = fmul(coef_b, coef_d);
                    m_left = M; m_next = 0;
                end
            end
        end
    end

    function automatic logic [M*M-1:0] m_flat();
        logic [M*M-1:0] f;
        for (int i = 0; i < M; i++) f[i*M +: M] = m_rows[i];
        return f;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_left > 0), "R4", "busy", busy, m_left > 0);
            chk(done == m_done, "R4", "done", done, m_done);
            chk(err == m_err, "R5", "err", err, m_err);
            chk(vec_u == m_u, "R2", "vec_u", vec_u, m_u);
            chk(mat_rows == m_flat(), "R3", "mat_rows", mat_rows, m_flat());
        end
    end

    task automatic go(logic [M-1:0] a, logic [M-1:0] b, logic [M-1:0] c,
                      logic [M-1:0] d, bit check_clear);
        @(negedge clk);
        start = 1'b1; coef_a = a; coef_b = b; coef_c = c; coef_d = d;
        @(negedge clk);
        start = 1'b0;
        if (check_clear) chk(mat_rows == '0, "R8", "rows after start", mat_rows, 0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * M; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    function automatic logic [M-1:0] sel_xor(logic [M-1:0] z);
        logic [M-1:0] s = '0;
        for (int i = 0; i < M; i++) if (z[i]) s ^= mat_rows[i*M +: M];
        return s;
    endfunction

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > WD_LIMIT && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err, "R1", "flags in reset", {busy, done, err}, 0);
        chk(mat_rows == '0 && vec_u == '0, "R1", "data in reset", mat_rows, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && vec_u == '0, "R1", "after reset", {busy, done, err}, 0);

        // R7 worked GF(16) case: A=1, B=a^13, C=1, D=a^3
        go(4'b0001, 4'b1101, 4'b0001, 4'b1000, 1'b1);
        wait_idle();
        chk(vec_u == 4'b0010, "R2", "constant a^16", vec_u, 4'b0010);
        chk(sel_xor(4'b1111) == vec_u, "R7", "root a^12", sel_xor(4'b1111), vec_u);
        chk(sel_xor(4'b1101) == vec_u, "R7", "root a^13", sel_xor(4'b1101), vec_u);

        // R6 start during a build is ignored
        go(4'b0011, 4'b0101, 4'b1001, 4'b0110, 1'b1);
        @(negedge clk);
        start = 1'b1; coef_a = 4'b1111; coef_b = 4'b1111; coef_c = 4'b0001; coef_d = 4'b0111;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk(vec_u == fmul(4'b0101, 4'b0110), "R6", "vec after ignored start",
            vec_u, fmul(4'b0101, 4'b0110));
        chk(mat_rows[M +: M] == lin_at(4'b0011, 4'b0101, 4'b1001, 4'b0110, 4'b0010),
            "R6", "row1 after ignored start", mat_rows[M +: M],
            lin_at(4'b0011, 4'b0101, 4'b1001, 4'b0110, 4'b0010));

        // R5 zero leading coefficient
        go('0, 4'b0111, 4'b0010, 4'b1011, 1'b1);
        repeat (M + 2) @(negedge clk);
        chk(err && !busy && vec_u == '0, "R5", "error holds", {err, busy}, 2'b10);
        go(4'b0100, 4'b0001, 4'b0000, 4'b0000, 1'b0);
        chk(!err, "R5", "err cleared by start", err, 0);
        wait_idle();

        // Varied coefficients, including back-to-back starts
        for (int n = 0; n < 30; n++) begin
            go(M'($urandom_range(1, (1 << M) - 1)), M'($urandom), M'($urandom), M'($urandom),
               1'b1);
            if (n % 3 != 0) wait_idle();
            else repeat (M - 1) @(negedge clk);
        end
        wait_idle();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule